// File: doc/BRIEF.md
# Outstanding Miss Tracker with Same-Line Merging

This block sits between the load buffers and the next cache level. It keeps a record of the first-level data cache misses that are still waiting for their line. Each miss request carries a byte address and the index of the load buffer that issued it.

A miss to a line that has no record yet takes a free tracking slot and queues one upstream request. A miss to a line that is already being fetched adds its load index to the existing slot, and nothing new goes upstream. When the fill for a line comes back, every load waiting on that line is reported complete in that same cycle, and the slot is freed.

The load pipeline keeps issuing loads while misses are outstanding. It stops only when every tracking slot is in use. At that point a stall is raised, and any miss presented while the stall is high is not accepted. Upstream requests leave in the order their slots were allocated, through a valid/ready handshake.

Top module: `lm_miss_tracker`

## Requirements
- R1: After synchronous reset, `stall` and `up_req_valid` are low and `done_mask` is all zero.
- R2: An accepted miss to a line with no outstanding record raises `up_req_valid` from the next cycle, with `up_req_line` equal to the miss address with its low 6 bits dropped (64-byte lines).
- R3: An accepted miss whose address falls in a line that is already outstanding produces no further upstream request. Address bits [5:0] are ignored in the comparison.
- R4: In a cycle with `fill_valid` high and `fill_line` matching an outstanding line, `done_mask` has bit k set for every load index k attached to that line, and no other bits set. In any cycle without a matching fill, `done_mask` is zero.
- R5: If an accepted miss and a fill target the same line in the same cycle, the merging load's bit is included in that cycle's `done_mask`, and the load is not left waiting.
- R6: `stall` is high exactly when four lines are outstanding. A miss presented while `stall` is high is ignored: it is never completed and causes no upstream request.
- R7: After a fill frees a slot while stalled, `stall` is low from the next cycle.
- R8: Upstream requests are issued in allocation order. While `up_req_valid` is high and `up_req_ready` is low, `up_req_valid` and `up_req_line` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | 32 | Byte address of the missing load |
| miss_lbi | input | 6 | Load-buffer index of the missing load (0..47) |
| stall | output | 1 | Tracker full; new miss requests are not accepted |
| up_req_valid | output | 1 | Upstream line request pending |
| up_req_ready | input | 1 | Next level accepts the request |
| up_req_line | output | 26 | Line address of the pending request |
| fill_valid | input | 1 | A requested line has returned |
| fill_line | input | 26 | Line address of the returning fill |
| done_mask | output | 48 | One bit per load buffer, completed this cycle |

## Verification
The assertions check on every cycle that no two live slots hold the same line. They also check that a held request stays stable, that completions appear only with a fill, that the request queue never overflows, that slots are only freed or merged while live, and that occupancy never grows while stalled. Merging is shown only by the bench scenarios, which count upstream requests against distinct lines. The same holds for the exact completion set of each fill, for the merge-with-fill race in one cycle, for a miss dropped during a stall never reappearing, and for allocation order under back-pressure. The bench checks all of these against a reference model that is updated from the requirements.

// File: rtl/lm_pkg.sv
package lm_pkg;
    localparam int ADDR_W_DEF    = 32;
    localparam int OFF_W_DEF     = 6;
    localparam int NUM_LOADS_DEF = 48;
    localparam int NUM_ENT_DEF   = 4;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_ALLOC = 2'd1,
        ACT_MERGE = 2'd2,
        ACT_FREE  = 2'd3
    } ent_act_e;

    function automatic int safe_clog2(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/lm_entry.sv
module lm_entry #(
    parameter int LINE_W    = 26,
    parameter int NUM_LOADS = 48
) (
    input  logic                   clk,
    input  logic                   rst,
    input  lm_pkg::ent_act_e       act,
    input  logic [LINE_W-1:0]      line_in,
    input  logic [NUM_LOADS-1:0]   bit_in,
    output logic                   valid,
    output logic [LINE_W-1:0]      line,
    output logic [NUM_LOADS-1:0]   waiters
);
    import lm_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            line    <= '0;
            waiters <= '0;
        end else begin
            unique case (act)
                ACT_ALLOC: begin
                    valid   <= 1'b1;
                    line    <= line_in;
                    waiters <= bit_in;
                end
                ACT_MERGE: waiters <= waiters | bit_in;
                ACT_FREE: begin
                    valid   <= 1'b0;
                    waiters <= '0;
                end
                default: ;
            endcase
        end
    end

    // R4: a slot may only be freed or merged into while it is live
    assert_act_on_live_R4: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_FREE || act == ACT_MERGE) |-> valid);
    // R6: allocation only into an empty slot
    assert_alloc_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_ALLOC) |-> !valid);
endmodule

// File: rtl/lm_req_queue.sv
module lm_req_queue #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic             not_empty,
    output logic [IDX_W-1:0] head_idx
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [IDX_W-1:0] slots [DEPTH];
    logic [IDX_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_pop;

    assign not_empty = (count != '0);
    assign head_idx  = slots[rd_ptr];
    assign do_pop    = pop && not_empty;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_idx;
                wr_ptr        <= bump(wr_ptr);
            end
            if (do_pop) rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(do_pop);
        end
    end

    // R8: the request order store never overflows
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        push |-> (count != CNT_W'(DEPTH)) || do_pop);
endmodule

// File: rtl/lm_miss_tracker.sv
module lm_miss_tracker #(
    parameter int ADDR_W    = lm_pkg::ADDR_W_DEF,
    parameter int OFF_W     = lm_pkg::OFF_W_DEF,
    parameter int NUM_LOADS = lm_pkg::NUM_LOADS_DEF,
    parameter int NUM_ENT   = lm_pkg::NUM_ENT_DEF,
    localparam int LINE_W   = ADDR_W - OFF_W,
    localparam int LBI_W    = lm_pkg::safe_clog2(NUM_LOADS),
    localparam int IDX_W    = lm_pkg::safe_clog2(NUM_ENT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 miss_valid,
    input  logic [ADDR_W-1:0]    miss_addr,
    input  logic [LBI_W-1:0]     miss_lbi,
    output logic                 stall,
    output logic                 up_req_valid,
    input  logic                 up_req_ready,
    output logic [LINE_W-1:0]    up_req_line,
    input  logic                 fill_valid,
    input  logic [LINE_W-1:0]    fill_line,
    output logic [NUM_LOADS-1:0] done_mask
);
    import lm_pkg::*;

    logic [NUM_ENT-1:0]   ent_valid;
    logic [LINE_W-1:0]    ent_line    [NUM_ENT];
    logic [NUM_LOADS-1:0] ent_waiters [NUM_ENT];
    ent_act_e             ent_act     [NUM_ENT];

    logic [NUM_ENT-1:0]   hit_vec, fill_vec, merge_vec, alloc_vec;
    logic [LINE_W-1:0]    miss_line;
    logic [NUM_LOADS-1:0] lbi_bit;
    logic                 accept, any_hit, alloc_go;
    logic [IDX_W-1:0]     alloc_idx, head_idx;

    assign miss_line = miss_addr[ADDR_W-1:OFF_W];
    assign lbi_bit   = NUM_LOADS'(1) << miss_lbi;
    assign stall     = &ent_valid;
    assign accept    = miss_valid && !stall;
    assign any_hit   = |hit_vec;
    assign alloc_go  = accept && !any_hit;

    always_comb begin
        alloc_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--)
            if (!ent_valid[i]) alloc_idx = IDX_W'(i);
    end

    always_comb begin
        done_mask = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            hit_vec[i]   = ent_valid[i] && (ent_line[i] == miss_line);
            fill_vec[i]  = fill_valid && ent_valid[i] && (ent_line[i] == fill_line);
            merge_vec[i] = accept && hit_vec[i];
            alloc_vec[i] = alloc_go && (alloc_idx == IDX_W'(i));
            if (fill_vec[i])
                done_mask = done_mask | ent_waiters[i] | (merge_vec[i] ? lbi_bit : '0);
        end
    end

    generate
        for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
            always_comb begin
                if (fill_vec[g])       ent_act[g] = ACT_FREE;
                else if (alloc_vec[g]) ent_act[g] = ACT_ALLOC;
                else if (merge_vec[g]) ent_act[g] = ACT_MERGE;
                else                   ent_act[g] = ACT_IDLE;
            end

            lm_entry #(.LINE_W(LINE_W), .NUM_LOADS(NUM_LOADS)) i_entry (
                .clk     (clk),
                .rst     (rst),
                .act     (ent_act[g]),
                .line_in (miss_line),
                .bit_in  (lbi_bit),
                .valid   (ent_valid[g]),
                .line    (ent_line[g]),
                .waiters (ent_waiters[g])
            );
        end
    endgenerate

    lm_req_queue #(.DEPTH(NUM_ENT), .IDX_W(IDX_W)) i_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (alloc_go),
        .push_idx  (alloc_idx),
        .pop       (up_req_ready),
        .not_empty (up_req_valid),
        .head_idx  (head_idx)
    );

    assign up_req_line = ent_line[head_idx];

    // ---------------- assertions ----------------
    logic dup_line;
    always_comb begin
        dup_line = 1'b0;
        for (int a = 0; a < NUM_ENT; a++)
            for (int b = a + 1; b < NUM_ENT; b++)
                if (ent_valid[a] && ent_valid[b] && ent_line[a] == ent_line[b])
                    dup_line = 1'b1;
    end

    // R3: merging keeps every outstanding line in one slot only
    assert_unique_line_R3: assert property (@(posedge clk) disable iff (rst)
        !dup_line);
    // R8: a request that is not taken stays put
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (up_req_valid && !up_req_ready) |=> (up_req_valid && $stable(up_req_line)));
    // R4: completions only appear alongside a fill
    assert_done_with_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (done_mask != '0) |-> fill_valid);
    // R6: occupancy never grows while stalled
    assert_no_growth_stalled_R6: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($countones(ent_valid) <= $countones($past(ent_valid))));
endmodule

// File: tb/test_lm_miss_tracker.sv
module test_lm_miss_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_addr = '0;
    logic [5:0]  miss_lbi = '0;
    logic        stall;
    logic        up_req_valid;
    logic        up_req_ready = 1'b0;
    logic [25:0] up_req_line;
    logic        fill_valid = 1'b0;
    logic [25:0] fill_line = '0;
    logic [47:0] done_mask;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lm_miss_tracker i_lm_miss_tracker (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_lbi(miss_lbi), .stall(stall), .up_req_valid(up_req_valid),
        .up_req_ready(up_req_ready), .up_req_line(up_req_line),
        .fill_valid(fill_valid), .fill_line(fill_line), .done_mask(done_mask)
    );

    // reference model
    logic        m_valid [NE];
    logic [25:0] m_line  [NE];
    logic [47:0] m_mask  [NE];
    int          m_q [NE];
    int          m_qn = 0;
    logic [25:0] pend [NE];
    int          pn = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input logic [25:0] ln);
        return {ln, 6'($urandom_range(0, 63))};
    endfunction

    task automatic step(input string tag, input logic mv, input logic [25:0] ml,
                        input logic [5:0] lb, input logic fv, input logic [25:0] fl,
                        input logic rdy);
        logic exp_stall, acc;
        logic [47:0] exp_done;
        int f, hit, fr;
        @(negedge clk);
        miss_valid = mv; miss_addr = mk_addr(ml); miss_lbi = lb;
        fill_valid = fv; fill_line = fl; up_req_ready = rdy;
        #1;
        exp_stall = 1'b1;
        for (int i = 0; i < NE; i++) if (!m_valid[i]) exp_stall = 1'b0;
        acc = mv && !exp_stall;
        f = -1; hit = -1;
        for (int i = 0; i < NE; i++) begin
            if (fv && m_valid[i] && m_line[i] == fl) f = i;
            if (m_valid[i] && m_line[i] == ml) hit = i;
        end
        exp_done = '0;
        if (f >= 0) exp_done = m_mask[f] | ((acc && hit == f) ? (48'd1 << lb) : 48'd0);
        chk({tag, " R6"}, "stall", 64'(stall), 64'(exp_stall));
        chk({tag, " R2"}, "up_req_valid", 64'(up_req_valid), 64'(m_qn > 0));
        if (m_qn > 0) chk({tag, " R8"}, "up_req_line", 64'(up_req_line), 64'(m_line[m_q[0]]));
        chk({tag, " R4"}, "done_mask", 64'(done_mask), 64'(exp_done));
        // model update
        if (m_qn > 0 && rdy) begin
            pend[pn] = m_line[m_q[0]]; pn++;
            for (int i = 0; i < NE - 1; i++) m_q[i] = m_q[i+1];
            m_qn--;
        end
        if (acc) begin
            if (hit >= 0) begin
                if (hit != f) m_mask[hit] = m_mask[hit] | (48'd1 << lb);
            end else begin
                fr = -1;
                for (int i = NE - 1; i >= 0; i--) if (!m_valid[i]) fr = i;
                m_valid[fr] = 1'b1; m_line[fr] = ml; m_mask[fr] = 48'd1 << lb;
                m_q[m_qn] = fr; m_qn++;
            end
        end
        if (f >= 0) begin
            m_valid[f] = 1'b0; m_mask[f] = '0;
            for (int i = 0; i < pn; i++)
                if (pend[i] == fl) begin
                    for (int j = i; j < pn - 1; j++) pend[j] = pend[j+1];
                    pn--;
                    break;
                end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NE; i++) begin m_valid[i] = 0; m_line[i] = '0; m_mask[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        chk("R1", "stall", 64'(stall), 64'd0);
        chk("R1", "up_req_valid", 64'(up_req_valid), 64'd0);
        chk("R1", "done_mask", 64'(done_mask), 64'd0);

        // R2/R3/R8: new line, merge with held request, then release
        step("R2", 1, 26'd10, 6'd1, 0, '0, 0);
        step("R3", 1, 26'd10, 6'd2, 0, '0, 0);
        step("R8", 0, '0, 6'd0, 0, '0, 0);
        step("R8", 1, 26'd11, 6'd3, 0, '0, 1);
        step("R3", 0, '0, 6'd0, 0, '0, 1);
        step("R3", 0, '0, 6'd0, 0, '0, 1);
        // R6: fill the tracker, then a dropped miss
        step("R6", 1, 26'd12, 6'd4, 0, '0, 1);
        step("R6", 1, 26'd13, 6'd5, 0, '0, 1);
        step("R6", 1, 26'd14, 6'd9, 0, '0, 1);
        step("R6", 1, 26'd10, 6'd7, 0, '0, 1);
        // R4/R7: fill line 10 completes loads 1 and 2 only
        step("R4", 0, '0, 6'd0, 1, 26'd10, 1);
        step("R7", 1, 26'd14, 6'd8, 0, '0, 1);
        step("R7", 0, '0, 6'd0, 0, '0, 1);
        // R5: merge and fill same line in one cycle
        step("R5", 1, 26'd11, 6'd20, 1, 26'd11, 1);
        step("R5", 0, '0, 6'd0, 0, '0, 1);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic mv, fv;
            logic [25:0] fl;
            mv = ($urandom_range(0, 3) != 0);
            fv = (pn > 0) && ($urandom_range(0, 2) == 0);
            fl = fv ? pend[$urandom_range(0, pn - 1)] : 26'd0;
            step("R4", mv, 26'($urandom_range(100, 105)), 6'($urandom_range(0, 47)),
                 fv, fl, 1'($urandom_range(0, 1)));
        end
        // drain
        for (int n = 0; n < 40; n++)
            step("R4", 0, '0, 6'd0, pn > 0, (pn > 0) ? pend[0] : 26'd0, 1);
        chk("R7", "drained stall", 64'(stall), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule